// File: doc/BRIEF.md
# I2C transaction offload sequencer

This block runs a short I2C master transaction from start to finish after one register write. It sits above a byte-level engine that handles all bus signalling. The sequencer hands that engine one command at a time (START, repeated START, STOP, write a byte, read a byte) and waits for each response. The transaction can be a write of 1 to 8 bytes, a read of 1 to 8 bytes, or a write followed by a read. The two phases of the last kind are joined either by a repeated START or by a STOP and a fresh START. Outgoing bytes come from two 32-bit TX words. Incoming bytes are packed into two 32-bit RX words.

Software loads the TX words, sets the mask, and writes the control word with the enable bit set. When the sequencer finishes, it sets the cause bit and records in the status bit whether the transaction failed. It then raises the interrupt if the mask allows it. Writing zero to control and to cause readies the block for the next transaction.

The FSM has these states: IDLE, START (issues START, or RESTART when joining phases), ADDR_HI (first address byte), ADDR_LO (second byte of a 10-bit address), WRITE, READ and STOP. Every command state issues its command once and then waits for the response. The transitions are:

- IDLE to START on launch.
- START to ADDR_HI.
- ADDR_HI to ADDR_LO when the address is extended, otherwise to WRITE or READ.
- ADDR_LO to WRITE or READ.
- WRITE loops until the last byte. It then goes to START (repeated START), to STOP with a chained read pending, or to STOP.
- READ loops until the last byte, then goes to STOP.
- ADDR_HI, ADDR_LO and WRITE go to STOP on any NACK.
- STOP goes to START when a chained read is pending, otherwise to IDLE and completion.

Top module: `txn_offload_seq`

## Requirements
- R1: The registers are selected by `reg_addr`: 0 control, 1 status, 2 cause, 3 mask, 4 TX low, 5 TX high, 6 RX low, 7 RX high. After reset all eight read as zero, `irq` is low and no command is issued.
- R2: A control write while idle launches a transaction only if bit 19 (enable) is set together with bit 0 (write) or bit 1 (read); the first command (`cmd_op` 1 = START) appears the cycle after the write. Enable with neither direction issues nothing and leaves cause at zero.
- R3: The target address is control bits [11:2]. With bit 12 clear, the single address byte is {addr[6:0], rw}. With bit 12 set, the first byte is {5'b11110, addr[9:8], rw} and the second is addr[7:0]. rw is 1 in the read phase.
- R4: The write phase sends control bits [15:13] plus one data bytes, each with `cmd_op` 4. Byte k is taken from TX low byte k for k < 4 and from TX high byte k-4 otherwise, with byte 0 in bits [7:0].
- R5: The read phase issues control bits [18:16] plus one reads (`cmd_op` 5). `cmd_last` is high only on the final read, which is answered with NACK. Received byte k is packed in the same layout as TX. RX bytes beyond the length read zero because RX is cleared at launch.
- R6: With both directions set, the write phase runs first. If bit 20 is set, a repeated START (`cmd_op` 2) follows and then the read-direction address. If bit 20 is clear, a STOP (`cmd_op` 3) and a new START follow instead.
- R7: A NACK response to an address byte or a write byte aborts the transaction: the next command is STOP, and status bit 0 reads 1 after completion.
- R8: Completion follows the response to the final STOP. It sets cause bit 0, and status bit 0 reads 0 when no NACK occurred.
- R9: `irq` is high exactly when cause bit 0 and mask bit 0 are both set.
- R10: A control write while a transaction runs is ignored: control reads back unchanged and the command sequence is unchanged.
- R11: Writing zero to control while idle clears control and status. Writing zero to cause clears it, except that a completion in the same cycle wins and cause stays 1.
- R12: Each command is a one-cycle `cmd_valid` pulse, and no new command is issued until `rsp_valid` answers the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the indexed register |
| cmd_valid | output | 1 | One-cycle command pulse to the byte engine |
| cmd_op | output | 3 | Command: 1 START, 2 RESTART, 3 STOP, 4 WRITE, 5 READ |
| cmd_byte | output | 8 | Byte to send for WRITE commands |
| cmd_last | output | 1 | On READ: final byte, answer with NACK |
| rsp_valid | input | 1 | Byte engine finished the pending command |
| rsp_nack | input | 1 | Target did not acknowledge a sent byte |
| rsp_byte | input | 8 | Byte received on a READ |
| irq | output | 1 | Interrupt request |

## Verification
Two of the block's functions can fall in the same cycle. The first pair is completion setting the cause bit while software clears it with a write of zero. The second pair is a control write arriving while the final STOP response is still pending. The bench's byte-engine model can place the cause-clearing write in the very negative half-cycle where it raises the response to the last STOP, so both land on one clock edge. The outcome is judged by reading cause afterwards: it must be 1, and the interrupt must still be raised. A separate test writes a different control word during a running transaction and checks both the readback and the full command log against the original launch.

// File: rtl/ofl_pkg.sv
package ofl_pkg;
    localparam int WORD_W  = 32;
    localparam int NBYTES  = 8;
    localparam int BPW     = WORD_W / 8;
    localparam int LEN_W   = $clog2(NBYTES);
    localparam int TADDR_W = 10;
    localparam int REG_AW  = 3;

    // control field positions (software-visible)
    localparam int C_WR      = 0;
    localparam int C_RD      = 1;
    localparam int C_ADDR_LO = 2;
    localparam int C_EXT     = 12;
    localparam int C_TXL_LO  = 13;
    localparam int C_RXL_LO  = 16;
    localparam int C_EN      = 19;
    localparam int C_RS      = 20;
    localparam int CTRL_W    = 21;

    localparam logic [REG_AW-1:0] IDX_CTRL   = 3'd0;
    localparam logic [REG_AW-1:0] IDX_STATUS = 3'd1;
    localparam logic [REG_AW-1:0] IDX_CAUSE  = 3'd2;
    localparam logic [REG_AW-1:0] IDX_MASK   = 3'd3;
    localparam logic [REG_AW-1:0] IDX_TXLO   = 3'd4;
    localparam logic [REG_AW-1:0] IDX_TXHI   = 3'd5;
    localparam logic [REG_AW-1:0] IDX_RXLO   = 3'd6;
    localparam logic [REG_AW-1:0] IDX_RXHI   = 3'd7;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_START   = 3'd1,
        OP_RESTART = 3'd2,
        OP_STOP    = 3'd3,
        OP_WRITE   = 3'd4,
        OP_READ    = 3'd5
    } op_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_WRITE,
        ST_READ,
        ST_STOP
    } state_t;
endpackage

// File: rtl/ofl_regs.sv
module ofl_regs
    import ofl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic              done_err,
    input  logic [WORD_W-1:0] rx_lo,
    input  logic [WORD_W-1:0] rx_hi,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [WORD_W-1:0] tx_lo,
    output logic [WORD_W-1:0] tx_hi,
    output logic              launch,
    output logic              launch_rd_only,
    output logic              cause_bit,
    output logic              mask_bit,
    output logic              irq
);
    logic status_q;
    logic ctrl_wr, ctrl_take;

    assign ctrl_wr        = reg_wr && (reg_addr == IDX_CTRL);
    assign ctrl_take      = ctrl_wr && !busy;
    assign launch         = ctrl_take && reg_wdata[C_EN] && (reg_wdata[C_WR] || reg_wdata[C_RD]);
    assign launch_rd_only = !reg_wdata[C_WR];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            status_q  <= 1'b0;
            cause_bit <= 1'b0;
            mask_bit  <= 1'b0;
            tx_lo     <= '0;
            tx_hi     <= '0;
        end else begin
            if (ctrl_take)
                ctrl_q <= reg_wdata[CTRL_W-1:0];

            if (done)
                status_q <= done_err;
            else if (ctrl_take && (launch || reg_wdata == '0))
                status_q <= 1'b0;

            // completion takes priority over a same-cycle clear
            if (done)
                cause_bit <= 1'b1;
            else if (reg_wr && reg_addr == IDX_CAUSE)
                cause_bit <= cause_bit & reg_wdata[0];

            if (reg_wr && reg_addr == IDX_MASK)
                mask_bit <= reg_wdata[0];
            if (reg_wr && reg_addr == IDX_TXLO)
                tx_lo <= reg_wdata;
            if (reg_wr && reg_addr == IDX_TXHI)
                tx_hi <= reg_wdata;
        end
    end

    assign irq = cause_bit && mask_bit;

    always_comb begin
        unique case (reg_addr)
            IDX_CTRL:   reg_rdata = {{(WORD_W-CTRL_W){1'b0}}, ctrl_q};
            IDX_STATUS: reg_rdata = {{(WORD_W-1){1'b0}}, status_q};
            IDX_CAUSE:  reg_rdata = {{(WORD_W-1){1'b0}}, cause_bit};
            IDX_MASK:   reg_rdata = {{(WORD_W-1){1'b0}}, mask_bit};
            IDX_TXLO:   reg_rdata = tx_lo;
            IDX_TXHI:   reg_rdata = tx_hi;
            IDX_RXLO:   reg_rdata = rx_lo;
            IDX_RXHI:   reg_rdata = rx_hi;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ofl_bytes.sv
module ofl_bytes
    import ofl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] tx_lo,
    input  logic [WORD_W-1:0] tx_hi,
    input  logic [LEN_W-1:0]  idx,
    output logic [7:0]        tx_byte,
    input  logic              rx_clr,
    input  logic              rx_we,
    input  logic [7:0]        rx_byte,
    output logic [WORD_W-1:0] rx_lo,
    output logic [WORD_W-1:0] rx_hi
);
    logic [NBYTES*8-1:0] tx_all;
    logic [NBYTES*8-1:0] rx_all;

    assign tx_all  = {tx_hi, tx_lo};
    assign tx_byte = tx_all[idx*8 +: 8];

    for (genvar g = 0; g < NBYTES; g++) begin : g_rx
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n || rx_clr)
                q <= '0;
            else if (rx_we && idx == LEN_W'(g))
                q <= rx_byte;
        end
        assign rx_all[g*8 +: 8] = q;
    end

    assign rx_lo = rx_all[WORD_W-1:0];
    assign rx_hi = rx_all[NBYTES*8-1:WORD_W];
endmodule

// File: rtl/ofl_fsm.sv
module ofl_fsm
    import ofl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic               launch_rd_only,
    input  logic [TADDR_W-1:0] tgt,
    input  logic               ext,
    input  logic [LEN_W-1:0]   tx_last,
    input  logic [LEN_W-1:0]   rx_last,
    input  logic               rd_en,
    input  logic               rs_en,
    input  logic [7:0]         tx_byte,
    input  logic               rsp_valid,
    input  logic               rsp_nack,
    output logic               busy,
    output logic               done,
    output logic               done_err,
    output logic               cmd_valid,
    output op_t                cmd_op,
    output logic [7:0]         cmd_byte,
    output logic               cmd_last,
    output logic [LEN_W-1:0]   byte_idx,
    output logic               rx_we
);
    state_t           state_q, state_d;
    logic             wait_q, wait_d;
    logic             rd_q, rd_d;      // read phase
    logic             rs_q, rs_d;      // next START is a repeated START
    logic             chain_q, chain_d; // read follows after STOP
    logic             err_q, err_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    logic             got;
    logic [7:0]       addr_hi;

    assign got     = wait_q && rsp_valid;
    assign addr_hi = ext ? {5'b11110, tgt[9:8], rd_q} : {tgt[6:0], rd_q};

    // next-state logic
    always_comb begin
        state_d = state_q;
        wait_d  = wait_q;
        rd_d    = rd_q;
        rs_d    = rs_q;
        chain_d = chain_q;
        err_d   = err_q;
        cnt_d   = cnt_q;
        done    = 1'b0;
        if (!wait_q && state_q != ST_IDLE)
            wait_d = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                if (launch) begin
                    state_d = ST_START;
                    wait_d  = 1'b0;
                    rd_d    = launch_rd_only;
                    rs_d    = 1'b0;
                    chain_d = 1'b0;
                    err_d   = 1'b0;
                    cnt_d   = '0;
                end
            end
            ST_START: begin
                if (got) begin
                    wait_d  = 1'b0;
                    state_d = ST_ADDR_HI;
                end
            end
            ST_ADDR_HI, ST_ADDR_LO: begin
                if (got) begin
                    wait_d = 1'b0;
                    cnt_d  = '0;
                    if (rsp_nack) begin
                        state_d = ST_STOP;
                        err_d   = 1'b1;
                        chain_d = 1'b0;
                    end else if (state_q == ST_ADDR_HI && ext)
                        state_d = ST_ADDR_LO;
                    else
                        state_d = rd_q ? ST_READ : ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (got) begin
                    wait_d = 1'b0;
                    if (rsp_nack) begin
                        state_d = ST_STOP;
                        err_d   = 1'b1;
                        chain_d = 1'b0;
                    end else if (cnt_q == tx_last) begin
                        cnt_d = '0;
                        if (rd_en && rs_en) begin
                            state_d = ST_START;
                            rd_d    = 1'b1;
                            rs_d    = 1'b1;
                        end else begin
                            state_d = ST_STOP;
                            chain_d = rd_en;
                        end
                    end else
                        cnt_d = cnt_q + 1'b1;
                end
            end
            ST_READ: begin
                if (got) begin
                    wait_d = 1'b0;
                    if (cnt_q == rx_last)
                        state_d = ST_STOP;
                    else
                        cnt_d = cnt_q + 1'b1;
                end
            end
            ST_STOP: begin
                if (got) begin
                    wait_d = 1'b0;
                    if (chain_q) begin
                        state_d = ST_START;
                        rd_d    = 1'b1;
                        rs_d    = 1'b0;
                        chain_d = 1'b0;
                    end else begin
                        state_d = ST_IDLE;
                        done    = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wait_q  <= 1'b0;
            rd_q    <= 1'b0;
            rs_q    <= 1'b0;
            chain_q <= 1'b0;
            err_q   <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            wait_q  <= wait_d;
            rd_q    <= rd_d;
            rs_q    <= rs_d;
            chain_q <= chain_d;
            err_q   <= err_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        cmd_valid = !wait_q && state_q != ST_IDLE;
        cmd_op    = OP_NONE;
        cmd_byte  = '0;
        cmd_last  = 1'b0;
        unique case (state_q)
            ST_IDLE:    cmd_op = OP_NONE;
            ST_START:   cmd_op = rs_q ? OP_RESTART : OP_START;
            ST_ADDR_HI: begin
                cmd_op   = OP_WRITE;
                cmd_byte = addr_hi;
            end
            ST_ADDR_LO: begin
                cmd_op   = OP_WRITE;
                cmd_byte = tgt[7:0];
            end
            ST_WRITE: begin
                cmd_op   = OP_WRITE;
                cmd_byte = tx_byte;
            end
            ST_READ: begin
                cmd_op   = OP_READ;
                cmd_last = (cnt_q == rx_last);
            end
            ST_STOP:    cmd_op = OP_STOP;
            default:    cmd_op = OP_NONE;
        endcase
    end

    assign busy     = state_q != ST_IDLE;
    assign done_err = err_q;
    assign byte_idx = cnt_q;
    assign rx_we    = (state_q == ST_READ) && got;
endmodule

// File: rtl/txn_offload_seq.sv
module txn_offload_seq
    import ofl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [7:0]        cmd_byte,
    output logic              cmd_last,
    input  logic              rsp_valid,
    input  logic              rsp_nack,
    input  logic [7:0]        rsp_byte,
    output logic              irq
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [WORD_W-1:0] tx_lo, tx_hi, rx_lo, rx_hi;
    logic              launch, launch_rd_only, busy, done, done_err;
    logic              cause_bit, mask_bit, rx_we;
    logic [LEN_W-1:0]  byte_idx;
    logic [7:0]        tx_byte;
    op_t               op_e;

    ofl_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .done(done), .done_err(done_err),
        .rx_lo(rx_lo), .rx_hi(rx_hi),
        .ctrl_q(ctrl_q), .tx_lo(tx_lo), .tx_hi(tx_hi),
        .launch(launch), .launch_rd_only(launch_rd_only),
        .cause_bit(cause_bit), .mask_bit(mask_bit), .irq(irq)
    );

    ofl_bytes u_bytes (
        .clk(clk), .rst_n(rst_n),
        .tx_lo(tx_lo), .tx_hi(tx_hi), .idx(byte_idx), .tx_byte(tx_byte),
        .rx_clr(launch), .rx_we(rx_we), .rx_byte(rsp_byte),
        .rx_lo(rx_lo), .rx_hi(rx_hi)
    );

    ofl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .launch(launch), .launch_rd_only(launch_rd_only),
        .tgt(ctrl_q[C_ADDR_LO +: TADDR_W]), .ext(ctrl_q[C_EXT]),
        .tx_last(ctrl_q[C_TXL_LO +: LEN_W]), .rx_last(ctrl_q[C_RXL_LO +: LEN_W]),
        .rd_en(ctrl_q[C_RD]), .rs_en(ctrl_q[C_RS]),
        .tx_byte(tx_byte), .rsp_valid(rsp_valid), .rsp_nack(rsp_nack),
        .busy(busy), .done(done), .done_err(done_err),
        .cmd_valid(cmd_valid), .cmd_op(op_e), .cmd_byte(cmd_byte), .cmd_last(cmd_last),
        .byte_idx(byte_idx), .rx_we(rx_we)
    );

    assign cmd_op = op_e;
endmodule

// File: rtl/ofl_chk.sv
module ofl_chk
    import ofl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic              wd_en,
    input logic              wd_wr,
    input logic              wd_rd,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic              rsp_valid,
    input logic              rsp_nack,
    input logic              irq,
    input logic              busy,
    input logic              done,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic              cause_bit,
    input logic              mask_bit
);
    logic [2:0] last_op;
    logic       outstanding;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_op     <= OP_NONE;
            outstanding <= 1'b0;
        end else begin
            if (cmd_valid) begin
                last_op     <= cmd_op;
                outstanding <= 1'b1;
            end else if (rsp_valid)
                outstanding <= 1'b0;
        end
    end

    // R12
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !outstanding);

    // R12
    pulse_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R2
    launch_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_wr && reg_addr == IDX_CTRL && wd_en && (wd_wr || wd_rd))
        |=> (cmd_valid && cmd_op == OP_START));

    // R7
    nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_nack && outstanding && last_op == OP_WRITE)
        |=> (cmd_valid && cmd_op == OP_STOP));

    // R10
    busy_ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == IDX_CTRL) |=> $stable(ctrl_q));

    // R11
    done_sets_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cause_bit);

    // R9
    done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mask_bit && !(reg_wr && reg_addr == IDX_MASK)) |=> irq);
endmodule

bind txn_offload_seq ofl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .wd_en(reg_wdata[ofl_pkg::C_EN]), .wd_wr(reg_wdata[ofl_pkg::C_WR]),
    .wd_rd(reg_wdata[ofl_pkg::C_RD]),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .rsp_valid(rsp_valid), .rsp_nack(rsp_nack),
    .irq(irq), .busy(busy), .done(done), .ctrl_q(ctrl_q),
    .cause_bit(cause_bit), .mask_bit(mask_bit)
);

// File: tb/txn_offload_seq_bench.sv
`timescale 1ns/1ps
module txn_offload_seq_bench;
    import ofl_pkg::*;

    localparam int RSP_LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd_valid, cmd_last;
    logic [2:0]  cmd_op;
    logic [7:0]  cmd_byte;
    logic        rsp_valid = 1'b0, rsp_nack = 1'b0;
    logic [7:0]  rsp_byte = '0;
    logic        irq;

    int checks = 0, errors = 0;
    logic [11:0] log_e [64];
    logic [11:0] exp_e [64];
    int log_n = 0, exp_n = 0, rd_cnt = 0, nack_at = -1;
    logic [7:0] rd_base = 8'h80;
    logic collide = 1'b0, coll_active = 1'b0;

    txn_offload_seq u_txn_offload_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_last(cmd_last),
        .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_byte(rsp_byte), .irq(irq)
    );

    always #4 clk = ~clk;

    // byte engine model
    initial begin
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            rsp_nack  = 1'b0;
            if (coll_active) begin
                reg_wr      = 1'b0;
                coll_active = 1'b0;
            end
            if (rst_n && cmd_valid) begin
                logic [2:0] op;
                logic       nk;
                logic [7:0] rb;
                op = cmd_op;
                if (log_n < 64) log_e[log_n] = {op, cmd_last, cmd_byte};
                nk = (op == OP_WRITE) && (log_n == nack_at);
                rb = 8'h00;
                if (op == OP_READ) begin
                    rb = rd_base + 8'(rd_cnt);
                    rd_cnt++;
                end
                log_n++;
                repeat (RSP_LAT) @(negedge clk);
                rsp_valid = 1'b1;
                rsp_nack  = nk;
                rsp_byte  = rb;
                if (collide && op == OP_STOP) begin
                    reg_wr      = 1'b1;
                    reg_addr    = IDX_CAUSE;
                    reg_wdata   = 32'h0;
                    coll_active = 1'b1;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish (actual hung, expected finished)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic push(input logic [2:0] op, input logic [7:0] b, input logic last);
        exp_e[exp_n] = {op, last, b};
        exp_n++;
    endtask

    task automatic prep(input int nk);
        wr(IDX_CTRL, 32'h0);
        wr(IDX_CAUSE, 32'h0);
        log_n = 0; exp_n = 0; rd_cnt = 0; nack_at = nk;
    endtask

    task automatic wait_done(input string tag);
        logic [31:0] v;
        v = 0;
        for (int i = 0; i < 3000; i++) begin
            rd(IDX_CAUSE, v);
            if (v[0]) break;
        end
        check({tag, " completion"}, v, 32'h1);
        repeat (20) @(negedge clk);
    endtask

    task automatic compare_log(input string tag);
        check({tag, " command count"}, log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++)
            check($sformatf("%s command %0d {op,last,byte}", tag, i), log_e[i], exp_e[i]);
    endtask

    function automatic logic [31:0] ctl(input bit w, input bit r, input logic [9:0] a,
                                        input bit ext, input int txn, input int rxn, input bit rs);
        ctl = 0;
        ctl[C_WR] = w; ctl[C_RD] = r; ctl[C_ADDR_LO +: 10] = a; ctl[C_EXT] = ext;
        ctl[C_TXL_LO +: 3] = 3'(txn - 1); ctl[C_RXL_LO +: 3] = 3'(rxn - 1);
        ctl[C_EN] = 1'b1; ctl[C_RS] = rs;
    endfunction

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check($sformatf("R1 reset reg %0d", a), v, 0);
        end
        check("R1 reset irq", {31'b0, irq}, 0);
        check("R1 reset cmd_valid", {31'b0, cmd_valid}, 0);
    endtask

    task automatic t_write3;
        logic [31:0] v;
        prep(-1);
        wr(IDX_TXLO, 32'h33221100);
        wr(IDX_CTRL, ctl(1, 0, 10'h050, 0, 3, 1, 0));
        wait_done("R4 write3");
        push(OP_START, 0, 0); push(OP_WRITE, 8'hA0, 0);
        push(OP_WRITE, 8'h00, 0); push(OP_WRITE, 8'h11, 0); push(OP_WRITE, 8'h22, 0);
        push(OP_STOP, 0, 0);
        compare_log("R3 R4 write3");
        rd(IDX_STATUS, v); check("R8 clean status", v, 0);
        check("R9 irq with mask set", {31'b0, irq}, 1);
    endtask

    task automatic t_read8;
        logic [31:0] v;
        prep(-1);
        rd_base = 8'h80;
        wr(IDX_CTRL, ctl(0, 1, 10'h021, 0, 1, 8, 0));
        wait_done("R5 read8");
        push(OP_START, 0, 0); push(OP_WRITE, 8'h43, 0);
        for (int i = 0; i < 8; i++) push(OP_READ, 0, i == 7);
        push(OP_STOP, 0, 0);
        compare_log("R5 read8");
        rd(IDX_RXLO, v); check("R5 rx low packing", v, 32'h83828180);
        rd(IDX_RXHI, v); check("R5 rx high packing", v, 32'h87868584);
    endtask

    task automatic t_combo_rs10;
        logic [31:0] v;
        prep(-1);
        rd_base = 8'hC0;
        wr(IDX_TXLO, 32'h0000BBAA);
        wr(IDX_CTRL, ctl(1, 1, 10'h2A5, 1, 2, 3, 1));
        wait_done("R6 combo rs");
        push(OP_START, 0, 0); push(OP_WRITE, 8'hF4, 0); push(OP_WRITE, 8'hA5, 0);
        push(OP_WRITE, 8'hAA, 0); push(OP_WRITE, 8'hBB, 0);
        push(OP_RESTART, 0, 0); push(OP_WRITE, 8'hF5, 0); push(OP_WRITE, 8'hA5, 0);
        push(OP_READ, 0, 0); push(OP_READ, 0, 0); push(OP_READ, 0, 1);
        push(OP_STOP, 0, 0);
        compare_log("R3 R6 combo 10-bit rs");
        rd(IDX_RXLO, v); check("R5 rx low short", v, 32'h00C2C1C0);
        rd(IDX_RXHI, v); check("R5 rx high cleared at launch", v, 32'h0);
    endtask

    task automatic t_combo_stop;
        prep(-1);
        rd_base = 8'h10;
        wr(IDX_TXLO, 32'h0000005A);
        wr(IDX_CTRL, ctl(1, 1, 10'h011, 0, 1, 1, 0));
        wait_done("R6 combo stop");
        push(OP_START, 0, 0); push(OP_WRITE, 8'h22, 0); push(OP_WRITE, 8'h5A, 0);
        push(OP_STOP, 0, 0); push(OP_START, 0, 0); push(OP_WRITE, 8'h23, 0);
        push(OP_READ, 0, 1); push(OP_STOP, 0, 0);
        compare_log("R6 combo stop-start");
    endtask

    task automatic t_addr_nack;
        logic [31:0] v;
        prep(1);
        wr(IDX_CTRL, ctl(1, 0, 10'h07F, 0, 2, 1, 0));
        wait_done("R7 addr nack");
        push(OP_START, 0, 0); push(OP_WRITE, 8'hFE, 0); push(OP_STOP, 0, 0);
        compare_log("R7 addr nack");
        rd(IDX_STATUS, v); check("R7 error after addr nack", v, 1);
    endtask

    task automatic t_data_nack;
        logic [31:0] v;
        prep(3);
        wr(IDX_TXLO, 32'h44332211);
        wr(IDX_CTRL, ctl(1, 1, 10'h030, 0, 4, 2, 1));
        wait_done("R7 data nack");
        push(OP_START, 0, 0); push(OP_WRITE, 8'h60, 0);
        push(OP_WRITE, 8'h11, 0); push(OP_WRITE, 8'h22, 0); push(OP_STOP, 0, 0);
        compare_log("R7 data nack");
        rd(IDX_STATUS, v); check("R7 error after data nack", v, 1);
        wr(IDX_CTRL, 32'h0);
        rd(IDX_CTRL, v); check("R11 control cleared", v, 0);
        rd(IDX_STATUS, v); check("R11 status cleared", v, 0);
        wr(IDX_CAUSE, 32'h0);
        rd(IDX_CAUSE, v); check("R11 cause cleared", v, 0);
    endtask

    task automatic t_busy_write;
        logic [31:0] v, c;
        prep(-1);
        wr(IDX_TXLO, 32'h0000BEEF);
        c = ctl(1, 0, 10'h040, 0, 2, 1, 0);
        wr(IDX_CTRL, c);
        repeat (5) @(negedge clk);
        wr(IDX_CTRL, ctl(0, 1, 10'h010, 0, 1, 1, 0));
        rd(IDX_CTRL, v); check("R10 control unchanged while busy", v, c);
        wait_done("R10 busy write");
        push(OP_START, 0, 0); push(OP_WRITE, 8'h80, 0);
        push(OP_WRITE, 8'hEF, 0); push(OP_WRITE, 8'hBE, 0); push(OP_STOP, 0, 0);
        compare_log("R10 sequence unchanged");
    endtask

    task automatic t_no_dir;
        logic [31:0] v;
        prep(-1);
        v = 0; v[C_EN] = 1'b1; v[C_ADDR_LO +: 10] = 10'h055;
        wr(IDX_CTRL, v);
        repeat (40) @(negedge clk);
        check("R2 no command without direction", log_n, 0);
        rd(IDX_CAUSE, v); check("R2 cause stays zero", v, 0);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        prep(-1);
        wr(IDX_MASK, 32'h0);
        wr(IDX_TXLO, 32'h00000077);
        wr(IDX_CTRL, ctl(1, 0, 10'h012, 0, 1, 1, 0));
        wait_done("R9 masked");
        check("R9 irq low when masked", {31'b0, irq}, 0);
        wr(IDX_MASK, 32'h1);
        check("R9 irq high when unmasked", {31'b0, irq}, 1);
        wr(IDX_CAUSE, 32'h0);
        check("R9 irq low after cause clear", {31'b0, irq}, 0);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        prep(-1);
        wr(IDX_TXLO, 32'h00000099);
        collide = 1'b1;
        wr(IDX_CTRL, ctl(1, 0, 10'h013, 0, 1, 1, 0));
        wait_done("R11 collision");
        collide = 1'b0;
        rd(IDX_CAUSE, v); check("R11 completion wins over same-cycle clear", v, 1);
        check("R9 irq after collision", {31'b0, irq}, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        wr(IDX_MASK, 32'h1);
        t_write3();
        t_read8();
        t_combo_rs10();
        t_combo_stop();
        t_addr_nack();
        t_data_nack();
        t_busy_write();
        t_no_dir();
        t_mask();
        t_collide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule